// File: doc/BRIEF.md
# Double-Buffered Clock-Synchronous Serial Transmitter

This block sends bytes over a two-wire synchronous link. One wire carries a serial clock that the block generates. The other carries the data bits, most significant bit first. Software runs it through a small register bus, with a one-cycle write strobe and a combinational read mux.

The transmit path holds two bytes. A holding register takes a byte from software. A shift register sends the previous byte onto the line. When the shifter is free, the held byte moves into it. Two status flags drive polling flow control:
- The empty flag reports that the holding register can take a byte.
- The end flag reports that the line has gone quiet after the last bit.

Software first programs the clock divider, then sets the enable bit, then feeds bytes whenever the empty flag reads 1. It waits for the end flag before it clears the enable bit.

Register map, on a 2-bit address:
- 0 (control): bit 0 is the enable.
- 1 (divider): each half period of the serial clock lasts divider+1 system clocks.
- 2 (status):
  - bit 0 is the empty flag.
  - bit 1 is the end flag.
  - bit 2 is the overrun flag.
  - Writing a 0 to bit 1 or bit 2 clears that flag. Writing a 1 leaves it unchanged.
- 3 (transmit data): write only. It reads as zero.

The register bus carries no streaming data, so it has no valid/ready pair. Back-pressure is the empty flag. A write made while the flag is 0 is refused, and the overrun flag records the refusal.

Top module: `sync_tx_unit`

## Requirements
- R1: After reset:
  - The control register reads 0.
  - The divider register reads DIV_RESET.
  - The status register reads 0x03 (empty=1, end=1, overrun=0).
  - The serial clock is high.
- R2: A write to the data register while enabled and empty is accepted. In the next cycle the empty flag (status bit 0) reads 0, with no software clear.
- R3: One cycle after an accepted write to an idle transmitter, the byte moves into the shift register. At that transfer the empty flag returns to 1 and the end flag (status bit 1) is cleared.
- R4: The serial clock behaves as follows:
  - It idles high.
  - Each of its half periods lasts divider+1 system clocks, so rising edges are 2*(divider+1) clocks apart.
  - The data line never changes on a rising edge.
  - The bits captured on the rising edges reproduce the byte, MSB first.
- R5: A byte accepted while the shifter is busy is sent right after the current byte. The spacing between rising edges stays 2*(divider+1) across the byte boundary.
- R6: The end flag rises exactly divider+1 clocks after the last rising edge of a byte with nothing held. At that point the shifter is idle.
- R7: Writing 1s to the status register changes no flag. Writing 0 to bit 2 clears only the overrun flag. Writing 0 to bit 1 clears only the end flag.
- R8: A data write while the empty flag is 0 is dropped: the byte is never sent. The write sets the overrun flag (status bit 2).
- R9: Clearing the enable does three things:
  - The shifter returns to idle within one further cycle, and the serial clock goes high.
  - The held byte is discarded, and the empty flag reads 1.
  - No further serial clock edges appear.
- R10: A data write while disabled is ignored: the empty flag stays 1 and overrun is unchanged. After enabling, nothing is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational on bus_addr) |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data, changes on falling edges |

## Verification
The bench builds the block with its defaults: 8-bit bytes, an 8-bit divider and a reset divider of 3. It then reprograms the divider at run time to values from 0 to 5. Short half periods keep each byte within a few dozen cycles. This makes the exact timing checks possible: edge spacing, end-flag latency after the final rising edge, and seamless back-to-back loading. Writes that collide with a busy or disabled transmitter are placed inside a byte whose timing is known.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] REG_DATA = 2'd3;

  localparam int ST_EMPTY = 0;
  localparam int ST_END   = 1;
  localparam int ST_OVR   = 2;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;
endpackage

// File: rtl/sync_tx_regs.sv
module sync_tx_regs
  import sync_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              xfer_load,
  input  logic              xfer_done,
  output logic              en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              full_o,
  output logic              txend_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] bus_rdata
);
  logic en_q, empty_q, txend_q, ovr_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] hold_q;
  logic wr_ctrl, wr_div, wr_stat, wr_data;

  always_comb begin
    wr_ctrl = bus_we && (bus_addr == REG_CTRL);
    wr_div  = bus_we && (bus_addr == REG_DIV);
    wr_stat = bus_we && (bus_addr == REG_STAT);
    wr_data = bus_we && (bus_addr == REG_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      div_q   <= DIV_W'(DIV_RESET);
      hold_q  <= '0;
      empty_q <= 1'b1;
      txend_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[0];
      if (wr_div)  div_q <= bus_wdata[DIV_W-1:0];

      if (!en_q) begin
        empty_q <= 1'b1;
      end else if (xfer_load) begin
        empty_q <= 1'b1;
      end else if (wr_data && empty_q) begin
        hold_q  <= bus_wdata;
        empty_q <= 1'b0;
      end

      if (wr_data && en_q && !empty_q) ovr_q <= 1'b1;
      else if (wr_stat && !bus_wdata[ST_OVR]) ovr_q <= 1'b0;

      if (xfer_done) txend_q <= 1'b1;
      else if (xfer_load) txend_q <= 1'b0;
      else if (wr_stat && !bus_wdata[ST_END]) txend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata[0] = en_q;
      REG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      REG_STAT: begin
        bus_rdata[ST_EMPTY] = empty_q;
        bus_rdata[ST_END]   = txend_q;
        bus_rdata[ST_OVR]   = ovr_q;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign en_o    = en_q;
  assign div_o   = div_q;
  assign hold_o  = hold_q;
  assign full_o  = !empty_q;
  assign txend_o = txend_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/sync_tx_baud.sv
module sync_tx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              full,
  input  logic [DATA_W-1:0] data_in,
  input  logic              tick,
  output logic              load,
  output logic              done,
  output logic              busy,
  output logic              sclk,
  output logic              sdo
);
  localparam int LAST = 2 * DATA_W;
  localparam int PH_W = $clog2(LAST + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(LAST);

  sh_state_t         st_q;
  logic [PH_W-1:0]   ph_q;
  logic [DATA_W-2:0] rest_q;
  logic              sclk_q, sdo_q;
  logic              at_end;

  assign at_end = (st_q == SH_RUN) && tick && (ph_q == PH_LAST);
  assign load   = en && (((st_q == SH_IDLE) && full) || (at_end && full));
  assign done   = en && at_end && !full;
  assign busy   = (st_q == SH_RUN);
  assign sclk   = sclk_q;
  assign sdo    = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      ph_q   <= '0;
      rest_q <= '0;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b0;
    end else if (!en) begin
      st_q   <= SH_IDLE;
      ph_q   <= '0;
      rest_q <= '0;
      sclk_q <= 1'b1;
    end else begin
      case (st_q)
        SH_IDLE: begin
          if (full) begin
            rest_q <= data_in[DATA_W-2:0];
            sdo_q  <= data_in[DATA_W-1];
            sclk_q <= 1'b1;
            ph_q   <= '0;
            st_q   <= SH_RUN;
          end
        end
        default: begin
          if (tick) begin
            if (ph_q == PH_LAST) begin
              if (full) begin
                rest_q <= data_in[DATA_W-2:0];
                sdo_q  <= data_in[DATA_W-1];
                sclk_q <= 1'b0;
                ph_q   <= PH_W'(1);
              end else begin
                st_q <= SH_IDLE;
                ph_q <= '0;
              end
            end else if (!ph_q[0]) begin
              sclk_q <= 1'b0;
              if (ph_q != '0) begin
                sdo_q  <= rest_q[DATA_W-2];
                rest_q <= {rest_q[DATA_W-3:0], 1'b0};
              end
              ph_q <= ph_q + 1'b1;
            end else begin
              sclk_q <= 1'b1;
              ph_q   <= ph_q + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sync_tx_unit.sv
module sync_tx_unit
  import sync_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              sdo
);
  logic              ctrl_en;
  logic [DIV_W-1:0]  div_val;
  logic [DATA_W-1:0] hold_byte;
  logic              reg_full, reg_txend, reg_ovr;
  logic              sh_load, sh_done, sh_busy, baud_tick;

  sync_tx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .xfer_load(sh_load), .xfer_done(sh_done),
    .en_o(ctrl_en), .div_o(div_val), .hold_o(hold_byte), .full_o(reg_full),
    .txend_o(reg_txend), .ovr_o(reg_ovr), .bus_rdata(bus_rdata)
  );

  sync_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(sh_busy), .div(div_val), .tick(baud_tick)
  );

  sync_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .full(reg_full), .data_in(hold_byte),
    .tick(baud_tick), .load(sh_load), .done(sh_done), .busy(sh_busy),
    .sclk(sclk), .sdo(sdo)
  );
endmodule

// File: rtl/sync_tx_chk.sv
module sync_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       busy,
  input logic       full,
  input logic       ovr,
  input logic       txend,
  input logic       load,
  input logic       sclk,
  input logic       sdo,
  input logic       bus_we,
  input logic [1:0] bus_addr
);
  logic data_wr;
  assign data_wr = bus_we && (bus_addr == 2'd3);

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);
  assert_sdo_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));
  assert_xfer_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !full);
  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txend) |-> !busy);
  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en && full) |=> ovr);
  assert_disable_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!full && !busy));
  assert_off_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !en) |=> ($stable(ovr) && !full));
endmodule

bind sync_tx_unit sync_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .busy(sh_busy), .full(reg_full),
  .ovr(reg_ovr), .txend(reg_txend), .load(sh_load), .sclk(sclk), .sdo(sdo),
  .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/sync_tx_unit_bench.sv
module sync_tx_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'h013C, 16'h0381,
                                         16'h02FF, 16'h0500, 16'h007E};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk, sdo;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  bit         mon_clear = 1'b0;
  logic       prev_sclk = 1'b1;
  logic [7:0] rx_shift = 8'h00;
  logic [7:0] rx_log [4];
  int rx_cnt = 0, nbits = 0, rises = 0, gap_err = 0, last_rise = 0, exp_gap = 8;
  bit have_rise = 1'b0;

  sync_tx_unit u_sync_tx_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clear) begin
      nbits = 0; rises = 0; rx_cnt = 0; gap_err = 0; have_rise = 1'b0;
    end else if (!prev_sclk && sclk) begin
      rx_shift = {rx_shift[6:0], sdo};
      nbits++; rises++;
      if (have_rise && (cyc - last_rise) != exp_gap) gap_err++;
      have_rise = 1'b1;
      last_rise = cyc;
      if (nbits == 8) begin
        if (rx_cnt < 4) rx_log[rx_cnt] = rx_shift;
        rx_cnt++;
        nbits = 0;
      end
    end
    prev_sclk = sclk;
  end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clear = 1'b1;
    @(negedge clk); #1 mon_clear = 1'b0;
  endtask

  task automatic wait_end(output int t_seen);
    logic [7:0] s;
    t_seen = -1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      rd(2'd2, s);
      if (s[1]) begin t_seen = cyc; break; end
    end
  endtask

  initial begin
    logic [7:0] s;
    int t_end, r0;
    idle(3);
    chk("R1", "sclk after reset", int'(sclk), 1);
    rd(2'd0, s); chk("R1", "ctrl reset", s, 0);
    rd(2'd1, s); chk("R1", "div reset", s, 3);
    rd(2'd2, s); chk("R1", "status reset", s, 3);
    rst_n = 1'b1;
    idle(2);

    // Vector table: {divider, byte}
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd1, VEC[v][15:8]);
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h04);
      exp_gap = 2 * (int'(VEC[v][15:8]) + 1);
      clear_mon();
      rd(2'd2, s); chk("R2", "empty before write", int'(s[0]), 1);
      wr(2'd3, VEC[v][7:0]);
      rd(2'd2, s); chk("R2", "empty cleared by write", int'(s[0]), 0);
      idle(1);
      rd(2'd2, s); chk("R3", "empty/end after transfer", int'(s[1:0]), 1);
      wait_end(t_end);
      chk("R6", "end flag latency", t_end - last_rise, int'(VEC[v][15:8]) + 1);
      chk("R4", "byte received", rx_cnt == 1 ? int'(rx_log[0]) : -1, int'(VEC[v][7:0]));
      chk("R4", "rise spacing errors", gap_err, 0);
      chk("R4", "sclk idle high", int'(sclk), 1);
    end

    // R5: back-to-back bytes, no idle gap
    wr(2'd1, 8'h01); exp_gap = 4;
    clear_mon();
    wr(2'd3, 8'h96);
    idle(1);
    wr(2'd3, 8'h3D);
    wait_end(t_end);
    chk("R5", "bytes received", rx_cnt, 2);
    chk("R5", "first byte", int'(rx_log[0]), 8'h96);
    chk("R5", "second byte", int'(rx_log[1]), 8'h3D);
    chk("R5", "rise spacing across boundary", gap_err, 0);
    chk("R5", "rise count", rises, 16);

    // R8: overrun drops the byte
    wr(2'd1, 8'h03); exp_gap = 8;
    clear_mon();
    wr(2'd3, 8'hA1);
    idle(1);
    wr(2'd3, 8'hB2);
    wr(2'd3, 8'hC4);
    rd(2'd2, s); chk("R8", "overrun flag", int'(s[2]), 1);
    wait_end(t_end);
    chk("R8", "bytes received", rx_cnt, 2);
    chk("R8", "first byte", int'(rx_log[0]), 8'hA1);
    chk("R8", "second byte (dropped byte absent)", int'(rx_log[1]), 8'hB2);

    // R7: flag clearing by writing zeros
    wr(2'd2, 8'hFF);
    rd(2'd2, s); chk("R7", "write ones no effect", s, 7);
    wr(2'd2, 8'h02);
    rd(2'd2, s); chk("R7", "clear overrun only", s, 3);
    wr(2'd2, 8'h04);
    rd(2'd2, s); chk("R7", "clear end only", s, 1);

    // R9: disable in the middle of a byte
    wr(2'd1, 8'h04); exp_gap = 10;
    clear_mon();
    wr(2'd3, 8'hC3);
    idle(1);
    wr(2'd3, 8'h69);
    idle(15);
    wr(2'd0, 8'h00);
    idle(1);
    rd(2'd2, s); chk("R9", "empty after disable", int'(s[0]), 1);
    chk("R9", "sclk high after disable", int'(sclk), 1);
    idle(1);
    r0 = rises;
    idle(60);
    chk("R9", "no edges while disabled", rises, r0);
    wr(2'd0, 8'h01);
    clear_mon();
    wr(2'd3, 8'h5A);
    wait_end(t_end);
    chk("R9", "held byte discarded", rx_cnt, 1);
    chk("R9", "fresh byte after re-enable", int'(rx_log[0]), 8'h5A);

    // R10: data write while disabled
    wr(2'd0, 8'h00);
    clear_mon();
    wr(2'd3, 8'h33);
    rd(2'd2, s); chk("R10", "empty/overrun after disabled write", int'({s[2], s[0]}), 1);
    wr(2'd0, 8'h01);
    idle(40);
    chk("R10", "nothing transmitted", rises, 0);
    rd(2'd2, s); chk("R10", "still empty", int'(s[0]), 1);

    summary();
  end
endmodule